// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block receives asynchronous serial characters on a single line. A one-cycle enable, `tick16`, marks sixteen sample points per bit time. A falling edge on the line is confirmed as a start bit at its midpoint. The block then collects five to eight data bits, least significant first, checks an optional parity bit and checks one or two stop bits. Each finished character goes into a receive FIFO together with three tags: parity error, framing error and break.

The host sees the character at the FIFO head on `rd_data` and removes it with `rd_pop`. The status byte `lsr` reports the following:

- data ready;
- a sticky overrun flag;
- the tags of the head character;
- a sticky summary bit, which records that a tagged character has entered the FIFO.

A one-cycle `lsr_rd` strobe clears both sticky bits.

The controlling state machine has six states:

- S_IDLE: waiting for a low line sample.
- S_START: counting to the start-bit midpoint. It moves to S_DATA if the line is still low there, and back to S_IDLE if it is high.
- S_DATA: sampling the data bits. After the last one it moves to S_PAR when parity is enabled, and to S_STOP when it is not.
- S_PAR: sampling the parity bit, then moving to S_STOP.
- S_STOP: sampling the stop bits. It moves to S_IDLE once the character is stored. It moves to S_BRK when the line was low for the whole frame, including the first stop bit.
- S_BRK: waiting for the line to return high, then moving to S_IDLE.

Top module: `uart_rx_lsr`

## Requirements
- R1: A low level on `rx` is accepted as a start bit only if `rx` is still low 8 ticks after the low was first seen. A shorter low pulse stores no character and `lsr[0]` stays 0.
- R2: `word_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive LSB first and are presented right-justified on `rd_data`, with the unused upper bits at 0.
- R3: The `lsr` bits are: bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit7 error summary, and bits 6 and 5 always 0. Bits 4..2 show the tags of the character at the FIFO head and are 0 when the FIFO is empty.
- R4: When `par_en`=1, a parity bit follows the data bits. The expected value depends on `par_even` and `par_stick`:
  - `par_stick`=1: the expected value is the inverse of `par_even`.
  - `par_stick`=0 and `par_even`=1: even parity over the data bits.
  - `par_stick`=0 and `par_even`=0: odd parity over the data bits.

  A parity bit that does not match sets the parity tag.
- R5: A stop bit sampled low sets the framing tag. With `stop2`=1, both stop bits are checked.
- R6: If `rx` stays low from the start bit through the first stop bit, exactly one character is stored. Its data is 0x00, the break and framing tags are set and the parity tag is clear. Nothing more is received until `rx` returns high.
- R7: If a character completes while the FIFO is full, the character is discarded, the FIFO contents are unchanged and `lsr[1]` is set. `lsr[1]` holds until `lsr_rd`, which clears it. A new overrun in the same cycle as `lsr_rd` keeps it set.
- R8: `lsr[7]` is set when a character with any tag enters the FIFO. It is cleared by `lsr_rd`.
- R9: `lsr[0]` is 1 exactly when the FIFO holds a character. `rd_data` shows the head character and is 0 when the FIFO is empty. `rd_pop` removes the head character, so characters come out in arrival order.
- R10: After reset, `lsr` is 0x00 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bit count select (5 to 8) |
| stop2 | input | 1 | Two stop bits when 1 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity, or forced value select |
| par_stick | input | 1 | Forced parity value |
| rd_pop | input | 1 | Remove head character |
| lsr_rd | input | 1 | Status read strobe, clears sticky bits |
| rd_data | output | 8 | Head character data |
| lsr | output | 8 | Line status byte |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and holds `tick16` high, so one bit lasts 16 clocks. With only four entries, five back-to-back characters reach the overrun case. The bench can then check, at low cost, that the four stored characters come out intact and in order. The short frames also let every word length, parity mode, single and double stop-bit error, a glitch on the line and a long break each be tried within a few thousand cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK
    } rx_state_t;

    typedef struct packed {
        logic              bi;
        logic              fe;
        logic              pe;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    localparam int ENTRY_W = $bits(rx_char_t);

endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx,
    input  logic [1:0] word_len,
    input  logic     stop2,
    input  logic     par_en,
    input  logic     par_even,
    input  logic     par_stick,
    output logic     ch_valid,
    output rx_char_t ch
);

    rx_state_t         state, state_nx;
    logic [3:0]        cnt;
    logic [2:0]        bitn;
    logic [CHAR_W-1:0] shreg;
    logic              zero_r;
    logic              pe_r;
    logic              stop_idx;

    logic              mid;
    logic [2:0]        last_bit;
    logic [CHAR_W-1:0] aligned;
    logic              par_exp;
    logic              brk_now;

    assign mid      = tick && (cnt == 4'd15);
    assign last_bit = 3'd4 + {1'b0, word_len};
    assign aligned  = shreg >> (2'd3 - word_len);
    assign par_exp  = par_stick ? ~par_even : (par_even ? ^aligned : ~^aligned);
    assign brk_now  = !stop_idx && !rx && zero_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (tick && !rx) state_nx = S_START;
            S_START: if (tick && cnt == 4'd7) state_nx = rx ? S_IDLE : S_DATA;
            S_DATA:  if (mid && bitn == last_bit) state_nx = par_en ? S_PAR : S_STOP;
            S_PAR:   if (mid) state_nx = S_STOP;
            S_STOP: begin
                if (mid) begin
                    if (brk_now)                      state_nx = S_BRK;
                    else if (!stop_idx && stop2 && rx) state_nx = S_STOP;
                    else                              state_nx = S_IDLE;
                end
            end
            S_BRK:   if (tick && rx) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ch_valid = 1'b0;
        ch       = '0;
        unique case (state)
            S_STOP: begin
                ch_valid = mid && (!rx || !stop2 || stop_idx);
                ch.bi    = brk_now;
                ch.fe    = !rx;
                ch.pe    = brk_now ? 1'b0 : pe_r;
                ch.data  = brk_now ? '0 : aligned;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            zero_r   <= 1'b0;
            pe_r     <= 1'b0;
            stop_idx <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: cnt <= '0;
                S_START: begin
                    bitn     <= '0;
                    shreg    <= '0;
                    zero_r   <= 1'b1;
                    pe_r     <= 1'b0;
                    stop_idx <= 1'b0;
                    if (tick) cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                end
                S_DATA: begin
                    if (tick) cnt <= cnt + 4'd1;
                    if (mid) begin
                        shreg  <= {rx, shreg[CHAR_W-1:1]};
                        bitn   <= bitn + 3'd1;
                        zero_r <= zero_r & ~rx;
                    end
                end
                S_PAR: begin
                    if (tick) cnt <= cnt + 4'd1;
                    if (mid) begin
                        pe_r   <= (rx != par_exp);
                        zero_r <= zero_r & ~rx;
                    end
                end
                S_STOP: begin
                    if (tick) cnt <= cnt + 4'd1;
                    if (mid) stop_idx <= 1'b1;
                end
                S_BRK: cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rx,
    input  logic [1:0]  word_len,
    input  logic        stop2,
    input  logic        par_en,
    input  logic        par_even,
    input  logic        par_stick,
    input  logic        rd_pop,
    input  logic        lsr_rd,
    output logic [7:0]  rd_data,
    output logic [7:0]  lsr
);

    rx_char_t             ch, head;
    logic                 ch_valid, ch_tagged;
    logic                 fifo_empty, fifo_full;
    logic [ENTRY_W-1:0]   fifo_rdata;
    logic [CNT_W-1:0]     fifo_cnt;
    logic                 oe_r, sum_r, avail;

    uart_rx_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rx        (rx),
        .word_len  (word_len),
        .stop2     (stop2),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .ch_valid  (ch_valid),
        .ch        (ch)
    );

    uart_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (ENTRY_W)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ch_valid),
        .wdata (ch),
        .pop   (rd_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    assign ch_tagged = ch.pe | ch.fe | ch.bi;
    assign avail     = !fifo_empty;
    assign head      = avail ? rx_char_t'(fifo_rdata) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_r  <= 1'b0;
            sum_r <= 1'b0;
        end else begin
            if (ch_valid && fifo_full) oe_r <= 1'b1;
            else if (lsr_rd)           oe_r <= 1'b0;
            if (ch_valid && !fifo_full && ch_tagged) sum_r <= 1'b1;
            else if (lsr_rd)                         sum_r <= 1'b0;
        end
    end

    assign rd_data = head.data;
    assign lsr     = {sum_r, 2'b00, head.bi, head.fe, head.pe, oe_r, avail};

endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    lsr,
    input logic          lsr_rd,
    input logic          rd_pop,
    input logic          ch_valid,
    input logic          ch_tagged,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_cnt
);

    p_tags_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lsr[0] |-> (lsr[4:2] == 3'b000));

    p_brk_fe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[4] |-> lsr[3]);

    p_oe_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && fifo_full) |=> lsr[1]);

    p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[1] && !lsr_rd) |=> lsr[1]);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && fifo_full && !rd_pop) |=> $stable(fifo_cnt));

    p_sum_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !fifo_full && ch_tagged) |=> lsr[7]);

    p_sum_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(ch_valid && ch_tagged)) |=> !lsr[7]);

    p_last_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && fifo_cnt == CW'(1) && !ch_valid) |=> !lsr[0]);

endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.CW(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsr       (lsr),
    .lsr_rd    (lsr_rd),
    .rd_pop    (rd_pop),
    .ch_valid  (ch_valid),
    .ch_tagged (ch_tagged),
    .fifo_full (fifo_full),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/test_uart_rx_lsr.sv
`timescale 1ns/1ps
module test_uart_rx_lsr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rx = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       stop2 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       rd_pop = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] lsr;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    uart_rx_lsr #(.FIFO_DEPTH(4)) i_uart_rx_lsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .rx        (rx),
        .word_len  (word_len),
        .stop2     (stop2),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .rd_pop    (rd_pop),
        .lsr_rd    (lsr_rd),
        .rd_data   (rd_data),
        .lsr       (lsr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] wl, input logic s2, input logic pen,
                       input logic pev, input logic pst);
        @(negedge clk);
        word_len = wl; stop2 = s2; par_en = pen; par_even = pev; par_stick = pst;
    endtask

    task automatic drive_bit(input logic b);
        rx = b;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic want_par(input logic [7:0] d, input int nb);
        logic [7:0] m;
        m = 8'hFF >> (8 - nb);
        if (par_stick) return ~par_even;
        return par_even ? ^(d & m) : ~^(d & m);
    endfunction

    task automatic send(input logic [7:0] d, input logic bad_par,
                        input logic s1, input logic s2v);
        int nb;
        nb = 5 + int'(word_len);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (par_en) drive_bit(want_par(d, nb) ^ bad_par);
        drive_bit(s1);
        if (stop2) drive_bit(s2v);
        rx = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    task automatic pop1;
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic read_lsr;
        @(negedge clk) lsr_rd = 1'b1;
        @(negedge clk) lsr_rd = 1'b0;
    endtask

    task automatic drain;
        for (int i = 0; i < 8; i++) if (lsr[0]) pop1();
        read_lsr();
    endtask

    task automatic t_reset;
        chk("R10 lsr after reset", lsr, 8'h00);
        chk("R10 rd_data after reset", rd_data, 8'h00);
    endtask

    task automatic t_glitch;
        @(negedge clk) rx = 1'b0;
        repeat (5) @(negedge clk);
        rx = 1'b1;
        repeat (64) @(negedge clk);
        chk("R1 glitch ignored, data ready", lsr[0], 1'b0);
    endtask

    task automatic t_formats;
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hA5, 1'b0, 1'b1, 1'b1);
        chk("R9 data ready after 8N1", lsr[0], 1'b1);
        chk("R2 8-bit data", rd_data, 8'hA5);
        chk("R3 no tags on clean char", lsr[4:2], 3'b000);
        pop1();
        chk("R9 empty after pop", lsr[0], 1'b0);
        chk("R9 rd_data zero when empty", rd_data, 8'h00);
        cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hF5, 1'b0, 1'b1, 1'b1);
        chk("R2 5-bit data right-justified", rd_data, 8'h15);
        pop1();
        cfg(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h2B, 1'b0, 1'b1, 1'b1);
        chk("R2 6-bit data", rd_data, 8'h2B);
        pop1();
        cfg(2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h5A, 1'b0, 1'b1, 1'b1);
        chk("R2 7-bit data with even parity", rd_data, 8'h5A);
        chk("R4 even parity correct, no PE", lsr[2], 1'b0);
        pop1();
        drain();
    endtask

    task automatic t_parity;
        cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        send(8'h37, 1'b1, 1'b1, 1'b1);
        send(8'h38, 1'b0, 1'b1, 1'b1);
        chk("R4 odd parity wrong, PE", lsr[2], 1'b1);
        chk("R3 head data with PE", rd_data, 8'h37);
        chk("R8 summary set", lsr[7], 1'b1);
        pop1();
        chk("R3 PE follows new head", lsr[2], 1'b0);
        chk("R9 second char in order", rd_data, 8'h38);
        pop1();
        read_lsr();
        chk("R8 summary cleared by status read", lsr[7], 1'b0);
        cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b1, 1'b1);
        chk("R4 forced-one parity accepted", lsr[2], 1'b0);
        pop1();
        cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b1);
        rx = 1'b1;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
        drive_bit(1'b1);
        drive_bit(1'b1);
        repeat (32) @(negedge clk);
        chk("R4 forced-zero parity with bit 1, PE", lsr[2], 1'b1);
        drain();
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_framing;
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h81, 1'b0, 1'b0, 1'b1);
        chk("R5 bad stop, FE", lsr[3], 1'b1);
        chk("R5 bad stop not break", lsr[4], 1'b0);
        chk("R5 data kept", rd_data, 8'h81);
        pop1();
        chk("R1 no spurious char after bad stop", lsr[0], 1'b0);
        cfg(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h42, 1'b0, 1'b1, 1'b0);
        chk("R5 second stop bit low, FE", lsr[3], 1'b1);
        pop1();
        send(8'h43, 1'b0, 1'b1, 1'b1);
        chk("R5 two good stop bits, no FE", lsr[3], 1'b0);
        chk("R5 two stop data", rd_data, 8'h43);
        drain();
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_break;
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk) rx = 1'b0;
        repeat (16 * 30) @(negedge clk);
        rx = 1'b1;
        repeat (32) @(negedge clk);
        chk("R6 break char stored", lsr[0], 1'b1);
        chk("R6 break data zero", rd_data, 8'h00);
        chk("R6 break tags BI FE no PE", lsr[4:2], 3'b110);
        chk("R8 summary on break", lsr[7], 1'b1);
        pop1();
        chk("R6 exactly one break char", lsr[0], 1'b0);
        read_lsr();
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        chk("R6 receive resumes after break", rd_data, 8'h3C);
        chk("R6 resumed char clean", lsr[4:2], 3'b000);
        drain();
    endtask

    task automatic t_overrun;
        cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) send(8'h11 + 8'(i), 1'b0, 1'b1, 1'b1);
        chk("R7 overrun flag set", lsr[1], 1'b1);
        for (int i = 0; i < 4; i++) begin
            chk("R7 stored char intact", rd_data, 8'h11 + 8'(i));
            pop1();
        end
        chk("R7 dropped char not stored", lsr[0], 1'b0);
        chk("R7 overrun held until read", lsr[1], 1'b1);
        read_lsr();
        chk("R7 overrun cleared by read", lsr[1], 1'b0);
        chk("R3 reserved bits zero", lsr[6:5], 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_glitch();
        t_formats();
        t_parity();
        t_framing();
        t_break();
        t_overrun();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule